// File: doc/BRIEF.md
# Edge-Selectable Interrupting GPIO Port

A port of up to sixteen general-purpose lines, controlled through a small synchronous register bus with a 16-bit data path. Each line is either an input or a driven output, set by its own direction bit. A line set as an output drives the value held in the output latch. A line set as an input is synchronized into the clock domain and watched for one edge, rising or falling, chosen by that line's polarity bit.

When the chosen edge arrives on an input line whose mask bit is clear, that line's bit in a sticky status register is set. A single interrupt output stays high as long as any status bit is set. Software clears status bits by writing ones to them. A pin-control register gates which sampled input levels the data-input register returns.

Top module: `gpio_edge_port`

## Requirements
- R1: After reset, the output latch, direction, edge-polarity, mask and pin-control registers read 0xFFFF, the status register reads 0x0000, `irq` is 0 and `pin_oe` is all zeros.
- R2: The byte offsets are 0x04 output latch, 0x08 direction, 0x0C edge polarity, 0x10 mask, 0x14 status and 0x18 pin control. Each reads back its stored value. `rd_data` is loaded on the clock edge that samples `rd_en` and otherwise holds its value.
- R3: A direction bit of 0 makes the line an output, so `pin_oe` is high for that line. A direction bit of 1 makes it an input. `pin_o` always shows the output latch, which takes effect on the edge after a write to 0x04 or 0x08.
- R4: A polarity bit of 1 selects a rising edge and 0 selects a falling edge. A selected edge on an unmasked input line sets its status bit, and `irq` rises, on the third clock edge after the pin changes: two synchronizer stages and then the edge compare.
- R5: An edge on a line that is masked (mask bit 1) or is an output (direction bit 0) is dropped. Clearing the mask or the direction bit afterwards does not make that edge appear.
- R6: Writing to 0x14 clears every status bit written as 1 and leaves the other bits unchanged. `irq` is high exactly while at least one status bit is set.
- R7: If a new edge event and a status clear hit the same bit on the same clock edge, the bit stays set.
- R8: Reading 0x00 returns the synchronized input levels ANDed with the pin-control register.
- R9: Writes to 0x00 have no effect. Reads at any offset other than 0x00 to 0x18 in steps of 4 return 0, and writes there change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 8 | Register byte offset |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 16 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 16 | Registered read data |
| pin_i | input | LINES | Asynchronous pin levels |
| pin_o | output | LINES | Output latch value |
| pin_oe | output | LINES | Per-line drive enable |
| irq | output | 1 | Interrupt, high while any status bit is set |

## Verification
Two things can act on the same status bit in one cycle: detection of a new edge, and a software clear of that bit. The bench provokes this by raising an input line two cycles before the clock edge on which its clear write lands, so the edge compare fires on that same edge. The bit must still read as set afterwards, while a clear that arrives alone must still remove it.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;
   localparam int BUS_W = 16;
   typedef logic [7:0] reg_ofs_t;

   localparam reg_ofs_t OFS_DIN  = 8'h00;
   localparam reg_ofs_t OFS_DOUT = 8'h04;
   localparam reg_ofs_t OFS_DIR  = 8'h08;
   localparam reg_ofs_t OFS_POL  = 8'h0C;
   localparam reg_ofs_t OFS_MASK = 8'h10;
   localparam reg_ofs_t OFS_STAT = 8'h14;
   localparam reg_ofs_t OFS_PCTL = 8'h18;

   function automatic logic ofs_known(input reg_ofs_t a);
      return (a == OFS_DIN)  || (a == OFS_DOUT) || (a == OFS_DIR) ||
             (a == OFS_POL)  || (a == OFS_MASK) || (a == OFS_STAT) ||
             (a == OFS_PCTL);
   endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int W      = 16,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stg[i] <= '0;
      end else begin
         stg[0] <= d;
         for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_edge_det.sv
module gpio_edge_det #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] cur,
   input  logic [W-1:0] rise_sel,
   input  logic [W-1:0] arm,
   output logic [W-1:0] evt
);
   logic [W-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= cur;
   end

   for (genvar g = 0; g < W; g++) begin : g_line
      logic rose, fell;
      assign rose   = cur[g] & ~prev_q[g];
      assign fell   = ~cur[g] & prev_q[g];
      assign evt[g] = arm[g] & (rise_sel[g] ? rose : fell);
   end
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
   import gpio_edge_pkg::*;
#(
   parameter int LINES = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  reg_ofs_t         addr,
   input  logic             wr_en,
   input  logic [BUS_W-1:0] wr_data,
   input  logic             rd_en,
   output logic [BUS_W-1:0] rd_data,
   input  logic [LINES-1:0] sample,
   input  logic [LINES-1:0] evt,
   output logic [LINES-1:0] dout_q,
   output logic [LINES-1:0] dir_q,
   output logic [LINES-1:0] pol_q,
   output logic [LINES-1:0] mask_q,
   output logic [LINES-1:0] stat_q
);
   logic [LINES-1:0] pctl_q;
   logic [LINES-1:0] wval;
   logic [LINES-1:0] clr;
   logic [BUS_W-1:0] rsel;

   assign wval = wr_data[LINES-1:0];
   assign clr  = (wr_en && addr == OFS_STAT) ? wval : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dout_q <= '1;
         dir_q  <= '1;
         pol_q  <= '1;
         mask_q <= '1;
         pctl_q <= '1;
      end else if (wr_en) begin
         case (addr)
            OFS_DOUT: dout_q <= wval;
            OFS_DIR:  dir_q  <= wval;
            OFS_POL:  pol_q  <= wval;
            OFS_MASK: mask_q <= wval;
            OFS_PCTL: pctl_q <= wval;
            default: ;
         endcase
      end
   end

   // a new event outranks a clear of the same bit
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stat_q <= '0;
      else        stat_q <= (stat_q & ~clr) | evt;
   end

   always_comb begin
      case (addr)
         OFS_DIN:  rsel = BUS_W'(sample & pctl_q);
         OFS_DOUT: rsel = BUS_W'(dout_q);
         OFS_DIR:  rsel = BUS_W'(dir_q);
         OFS_POL:  rsel = BUS_W'(pol_q);
         OFS_MASK: rsel = BUS_W'(mask_q);
         OFS_STAT: rsel = BUS_W'(stat_q);
         OFS_PCTL: rsel = BUS_W'(pctl_q);
         default:  rsel = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rd_data <= '0;
      else if (rd_en) rd_data <= rsel;
   end
endmodule

// File: rtl/gpio_edge_port.sv
module gpio_edge_port
   import gpio_edge_pkg::*;
#(
   parameter int LINES       = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [7:0]       addr,
   input  logic             wr_en,
   input  logic [15:0]      wr_data,
   input  logic             rd_en,
   output logic [15:0]      rd_data,
   input  logic [LINES-1:0] pin_i,
   output logic [LINES-1:0] pin_o,
   output logic [LINES-1:0] pin_oe,
   output logic             irq
);
   if (LINES < 1 || LINES > BUS_W) begin : g_bad_lines
      $error("LINES must lie between 1 and the bus width");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic [LINES-1:0] sample, evt, arm;
   logic [LINES-1:0] dout_q, dir_q, pol_q, mask_q, stat_q;

   gpio_sync #(.W(LINES), .STAGES(SYNC_STAGES)) i_sync (
      .clk(clk), .rst_n(rst_n), .d(pin_i), .q(sample)
   );

   assign arm = dir_q & ~mask_q;

   gpio_edge_det #(.W(LINES)) i_edge (
      .clk(clk), .rst_n(rst_n), .cur(sample), .rise_sel(pol_q),
      .arm(arm), .evt(evt)
   );

   gpio_regfile #(.LINES(LINES)) i_regs (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
      .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
      .sample(sample), .evt(evt), .dout_q(dout_q), .dir_q(dir_q),
      .pol_q(pol_q), .mask_q(mask_q), .stat_q(stat_q)
   );

   assign pin_o  = dout_q;
   assign pin_oe = ~dir_q;
   assign irq    = |stat_q;
endmodule

// File: rtl/gpio_edge_port_chk.sv
module gpio_edge_port_chk
   import gpio_edge_pkg::*;
#(
   parameter int LINES = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic [7:0]       addr,
   input logic             wr_en,
   input logic [15:0]      wr_data,
   input logic             rd_en,
   input logic [15:0]      rd_data,
   input logic [LINES-1:0] pin_oe,
   input logic [LINES-1:0] stat_q,
   input logic [LINES-1:0] mask_q,
   input logic [LINES-1:0] dir_q
);
   // R3
   oe_follows_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == OFS_DIR) |=> (pin_oe == ~$past(wr_data[LINES-1:0])));

   // R6
   status_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && addr == OFS_STAT) |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

   // R5
   blocked_line_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((stat_q & ~$past(stat_q) & ($past(mask_q) | ~$past(dir_q))) == '0));

   // R2
   rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rd_data));

   // R9
   unknown_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !ofs_known(addr)) |=> (rd_data == '0));
endmodule

bind gpio_edge_port gpio_edge_port_chk #(.LINES(LINES)) i_chk (
   .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
   .rd_en(rd_en), .rd_data(rd_data), .pin_oe(pin_oe), .stat_q(stat_q),
   .mask_q(mask_q), .dir_q(dir_q)
);

// File: tb/test_gpio_edge_port.sv
module test_gpio_edge_port;
   localparam int CLK_PERIOD = 10;
   localparam int N = 16;
   localparam int NVEC = 15;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [7:0]    addr = '0;
   logic          wr_en = 1'b0;
   logic [15:0]   wr_data = '0;
   logic          rd_en = 1'b0;
   logic [15:0]   rd_data;
   logic [N-1:0]  pin_i = '0;
   logic [N-1:0]  pin_o, pin_oe;
   logic          irq;

   int checks = 0;
   int fails  = 0;

   gpio_edge_port i_gpio_edge_port (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
      .rd_en(rd_en), .rd_data(rd_data), .pin_i(pin_i), .pin_o(pin_o),
      .pin_oe(pin_oe), .irq(irq)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   // {req id [3:0], write [0], offset [7:0], data [15:0], expected [15:0]}
   localparam logic [44:0] VEC [NVEC] = '{
      {4'd1, 1'b0, 8'h04, 16'h0000, 16'hFFFF}, // R1 output latch
      {4'd1, 1'b0, 8'h08, 16'h0000, 16'hFFFF}, // R1 direction
      {4'd1, 1'b0, 8'h0C, 16'h0000, 16'hFFFF}, // R1 polarity
      {4'd1, 1'b0, 8'h10, 16'h0000, 16'hFFFF}, // R1 mask
      {4'd1, 1'b0, 8'h14, 16'h0000, 16'h0000}, // R1 status
      {4'd1, 1'b0, 8'h18, 16'h0000, 16'hFFFF}, // R1 pin control
      {4'd2, 1'b1, 8'h04, 16'hA5C3, 16'h0000}, // R2 write latch
      {4'd2, 1'b0, 8'h04, 16'h0000, 16'hA5C3}, // R2 read latch
      {4'd2, 1'b1, 8'h0C, 16'h00F0, 16'h0000}, // R2 write polarity
      {4'd2, 1'b0, 8'h0C, 16'h0000, 16'h00F0}, // R2 read polarity
      {4'd2, 1'b1, 8'h0C, 16'hFFFF, 16'h0000}, // R2 restore polarity
      {4'd9, 1'b0, 8'h1C, 16'h0000, 16'h0000}, // R9 unknown read
      {4'd9, 1'b1, 8'h1C, 16'h5555, 16'h0000}, // R9 unknown write
      {4'd9, 1'b1, 8'h00, 16'h1234, 16'h0000}, // R9 input offset write
      {4'd9, 1'b0, 8'h04, 16'h0000, 16'hA5C3}  // R9 latch untouched
   };

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [7:0] a, input logic [15:0] d);
      @(negedge clk);
      addr = a; wr_data = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic bus_read(input logic [7:0] a, output logic [15:0] d);
      @(negedge clk);
      addr = a; rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
      d = rd_data;
   endtask

   task automatic settle();
      repeat (4) @(negedge clk);
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
   end

   initial begin
      logic [15:0] r;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 pins and interrupt out of reset
      check("R1 pin_oe", 16'(pin_oe), 16'h0000);
      check("R1 irq", {15'd0, irq}, 16'h0000);

      for (int i = 0; i < NVEC; i++) begin
         if (VEC[i][40]) bus_write(VEC[i][39:32], VEC[i][31:16]);
         else begin
            bus_read(VEC[i][39:32], r);
            check($sformatf("R%0d vector %0d", VEC[i][44:41], i), r, VEC[i][15:0]);
         end
      end

      // R3 direction drives enables, latch drives pins
      bus_write(8'h08, 16'hFF00);
      check("R3 oe", 16'(pin_oe), 16'h00FF);
      check("R3 pin_o", 16'(pin_o), 16'hA5C3);
      bus_write(8'h04, 16'h0F0F);
      check("R3 pin_o update", 16'(pin_o), 16'h0F0F);
      bus_write(8'h08, 16'hFFFF);
      check("R3 oe released", 16'(pin_oe), 16'h0000);

      // R8 input read gated by pin control
      pin_i = 16'h3C5A;
      settle();
      bus_read(8'h00, r);
      check("R8 full", r, 16'h3C5A);
      bus_write(8'h18, 16'h00FF);
      bus_read(8'h00, r);
      check("R8 gated", r, 16'h005A);
      bus_write(8'h18, 16'hFFFF);

      // R4 rising detection and its latency
      bus_write(8'h10, 16'h0000);
      pin_i = 16'h0000;
      settle();
      bus_read(8'h14, r);
      check("R4 falling ignored on rising lines", r, 16'h0000);
      @(negedge clk);
      pin_i = 16'h0008;
      repeat (2) @(negedge clk);
      check("R4 irq not yet", {15'd0, irq}, 16'h0000);
      @(negedge clk);
      check("R4 irq third edge", {15'd0, irq}, 16'h0001);
      bus_read(8'h14, r);
      check("R4 rising", r, 16'h0008);

      // R4 falling polarity on line 5
      bus_write(8'h0C, 16'hFFDF);
      pin_i = 16'h0028;
      settle();
      bus_read(8'h14, r);
      check("R4 rise on falling line", r, 16'h0008);
      pin_i = 16'h0008;
      settle();
      bus_read(8'h14, r);
      check("R4 falling", r, 16'h0028);

      // R6 write-one-to-clear
      bus_write(8'h14, 16'h0008);
      bus_read(8'h14, r);
      check("R6 partial clear", r, 16'h0020);
      check("R6 irq held", {15'd0, irq}, 16'h0001);
      bus_write(8'h14, 16'h0020);
      bus_read(8'h14, r);
      check("R6 all clear", r, 16'h0000);
      check("R6 irq low", {15'd0, irq}, 16'h0000);

      // R5 masked and output lines drop edges
      bus_write(8'h0C, 16'hFFFF);
      bus_write(8'h10, 16'h0100);
      bus_write(8'h08, 16'hFDFF);
      pin_i = 16'h0308;
      settle();
      bus_read(8'h14, r);
      check("R5 dropped", r, 16'h0000);
      bus_write(8'h10, 16'h0000);
      bus_write(8'h08, 16'hFFFF);
      settle();
      bus_read(8'h14, r);
      check("R5 not revealed", r, 16'h0000);
      check("R5 irq", {15'd0, irq}, 16'h0000);

      // R7 event and clear on the same edge
      @(negedge clk);
      pin_i = 16'h030A;
      @(negedge clk);
      @(negedge clk);
      addr = 8'h14; wr_data = 16'h0002; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
      bus_read(8'h14, r);
      check("R7 event wins", r, 16'h0002);
      bus_write(8'h14, 16'h0002);
      bus_read(8'h14, r);
      check("R7 lone clear", r, 16'h0000);

      finish_run();
   end
endmodule